// File: doc/BRIEF.md
# Reset Source Selector

This block routes one of two active-low reset lines to a single active-low reset output. Software or a controller presents a selection request on a control clock. The request is captured in a register on the rising edge, and that registered bit steers a plain combinational multiplexer. Because the path from the chosen reset input to the output holds no storage, an assertion or release on the chosen line reaches the output at once, even when no clock is running.

A change of choice only becomes visible after a capturing edge. If both reset lines carry the same level at that moment, the output does not move. If the levels differ, the output takes the level of the newly chosen line. The line that is not chosen has no influence on the output. A synchronous active-high reset on the control clock forces the choice back to line B. Glitch-free hand-over between unrelated reset domains and synchronization of the output are left to the surrounding logic.

Top module: `reset_mux_sel`

## Requirements
- R1: The request bit `sel_req` encodes the choice: 1 selects line A (`rst_a_n`) and 0 selects line B (`rst_b_n`). The output equals the level of the selected line.
- R2: `sel_req` is captured only on the rising edge of `clk`. Changes on `sel_req` between edges do not alter the output before the next edge.
- R3: While a line is selected, every change on it appears on `rst_out_n` without waiting for a clock edge.
- R4: Changes on the line that is not selected leave `rst_out_n` unchanged.
- R5: When the captured choice switches and the two lines hold different levels, `rst_out_n` takes the newly selected line's level right after that edge.
- R6: When the captured choice switches and the two lines hold equal levels, `rst_out_n` keeps its level.
- R7: While `rst` is high at a rising edge of `clk`, the choice is forced to line B whatever `sel_req` holds; after release the first capture happens at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock that captures the selection request |
| rst | input | 1 | Synchronous active-high reset of the selection register |
| sel_req | input | 1 | Selection request, 1 for line A, 0 for line B |
| rst_a_n | input | 1 | Active-low reset line A |
| rst_b_n | input | 1 | Active-low reset line B |
| rst_out_n | output | 1 | Active-low reset output following the selected line |

## Verification
The interesting collision is a choice switch at a clock edge coinciding with an asynchronous move on the newly selected line in the same cycle. The bench switches the choice from B to A while the lines differ, checks that the output jumps to A's level just after the edge, then moves A a fraction of a nanosecond later and checks that the output follows within the same clock period. A reference model of the captured choice, kept in the bench, judges every sample.

// File: rtl/rmx_pkg.sv
package rmx_pkg;

    typedef enum logic {
        SRC_B = 1'b0,
        SRC_A = 1'b1
    } src_e;

    typedef struct packed {
        logic line_a_n;
        logic line_b_n;
    } rst_pair_t;

    localparam src_e SRC_AT_RESET = SRC_B;

    function automatic logic pick_line(input rst_pair_t pair, input src_e src);
        return (src == SRC_A) ? pair.line_a_n : pair.line_b_n;
    endfunction

    function automatic src_e decode_req(input logic req);
        return req ? SRC_A : SRC_B;
    endfunction

endpackage

// File: rtl/rmx_sel_reg.sv
module rmx_sel_reg
    import rmx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    output src_e sel_q
);

    src_e pending;

    always_comb begin
        pending = decode_req(req);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= SRC_AT_RESET;
        end else begin
            sel_q <= pending;
        end
    end

endmodule

// File: rtl/rmx_mux.sv
module rmx_mux
    import rmx_pkg::*;
(
    input  rst_pair_t lines,
    input  src_e      sel,
    output logic      out_n
);

    always_comb begin
        out_n = pick_line(lines, sel);
    end

endmodule

// File: rtl/reset_mux_sel.sv
module reset_mux_sel
    import rmx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel_req,
    input  logic rst_a_n,
    input  logic rst_b_n,
    output logic rst_out_n
);

    src_e      sel_q;
    rst_pair_t lines;

    always_comb begin
        lines.line_a_n = rst_a_n;
        lines.line_b_n = rst_b_n;
    end

    rmx_sel_reg u_sel (
        .clk   (clk),
        .rst   (rst),
        .req   (sel_req),
        .sel_q (sel_q)
    );

    rmx_mux u_mux (
        .lines (lines),
        .sel   (sel_q),
        .out_n (rst_out_n)
    );

endmodule

// File: rtl/rmx_check.sv
module rmx_check (
    input logic clk,
    input logic rst,
    input logic sel_req,
    input logic rst_a_n,
    input logic rst_b_n,
    input logic rst_out_n,
    input logic sel_q
);

    p_reset_to_b_r7: assert property (@(posedge clk)
        rst |=> (sel_q == 1'b0));

    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (sel_q == $past(sel_req)));

    p_pass_a_r3: assert property (@(posedge clk) disable iff (rst)
        (sel_q && !$stable(rst_a_n)) |-> (rst_out_n == rst_a_n));

    p_pass_b_r1: assert property (@(posedge clk) disable iff (rst)
        (!sel_q && !$stable(rst_b_n)) |-> (rst_out_n == rst_b_n));

    p_ignore_unsel_r4: assert property (@(posedge clk) disable iff (rst)
        (!sel_q && $stable(sel_q) && $stable(rst_b_n)) |-> $stable(rst_out_n));

    p_equal_switch_r6: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sel_q) && $stable(rst_a_n) && $stable(rst_b_n)
         && (rst_a_n == rst_b_n)) |-> $stable(rst_out_n));

endmodule

bind reset_mux_sel rmx_check u_chk (
    .clk       (clk),
    .rst       (rst),
    .sel_req   (sel_req),
    .rst_a_n   (rst_a_n),
    .rst_b_n   (rst_b_n),
    .rst_out_n (rst_out_n),
    .sel_q     (sel_q)
);

// File: tb/tb_reset_mux_sel.sv
`timescale 1ns/1ps
module tb_reset_mux_sel;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_req = 1'b0;
    logic rst_a_n = 1'b0;
    logic rst_b_n = 1'b0;
    logic rst_out_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    reset_mux_sel dut (
        .clk       (clk),
        .rst       (rst),
        .sel_req   (sel_req),
        .rst_a_n   (rst_a_n),
        .rst_b_n   (rst_b_n),
        .rst_out_n (rst_out_n)
    );

    // Reference of the captured choice: 1 = line A, 0 = line B
    logic m_sel = 1'b0;
    always @(posedge clk) m_sel <= rst ? 1'b0 : sel_req;

    task automatic chk(input string tag, input logic exp);
        checks++;
        if (rst_out_n !== exp) begin
            errors++;
            $display("FAIL %s: rst_out_n=%b expected=%b", tag, rst_out_n, exp);
        end
        if (rst_out_n !== (m_sel ? rst_a_n : rst_b_n)) begin
            errors++;
            $display("FAIL %s model: rst_out_n=%b expected=%b", tag, rst_out_n,
                     m_sel ? rst_a_n : rst_b_n);
        end
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1; sel_req = 1'b1; rst_a_n = 1'b0; rst_b_n = 1'b1;
        after_edge(); after_edge();
        chk("R7 reset forces B", 1'b1);
        rst_b_n = 1'b0; #1;
        chk("R7 B followed in reset", 1'b0);
        rst_b_n = 1'b1; #1;
    endtask

    task automatic t_select_a();
        @(negedge clk);
        rst = 1'b0; sel_req = 1'b1; #1;
        chk("R2 no change before edge", 1'b1);
        after_edge();
        chk("R1 R5 A selected", 1'b0);
    endtask

    task automatic t_pass_and_ignore();
        @(negedge clk);
        rst_a_n = 1'b1; #1;
        chk("R3 A release passes", 1'b1);
        rst_a_n = 1'b0; #1;
        chk("R3 A assert passes", 1'b0);
        rst_b_n = 1'b0; #1;
        chk("R4 B ignored", 1'b0);
        rst_b_n = 1'b1; #1;
        chk("R4 B ignored again", 1'b0);
    endtask

    task automatic t_equal_switch();
        @(negedge clk);
        rst_a_n = 1'b1; rst_b_n = 1'b1; sel_req = 1'b0; #1;
        chk("R6 before equal switch", 1'b1);
        after_edge();
        chk("R6 equal switch to B", 1'b1);
        @(negedge clk);
        sel_req = 1'b1;
        after_edge();
        chk("R6 equal switch to A", 1'b1);
    endtask

    task automatic t_diff_switch();
        @(negedge clk);
        rst_a_n = 1'b0; rst_b_n = 1'b1; sel_req = 1'b0; #1;
        chk("R2 A still selected", 1'b0);
        after_edge();
        chk("R5 switch to B differing", 1'b1);
    endtask

    task automatic t_req_glitch();
        @(negedge clk);
        sel_req = 1'b1; #1;
        chk("R2 request pulse high", 1'b1);
        sel_req = 1'b0; #1;
        after_edge();
        chk("R2 pulse between edges ignored", 1'b1);
    endtask

    task automatic t_collide();
        @(negedge clk);
        rst_a_n = 1'b1; rst_b_n = 1'b0; sel_req = 1'b1; #1;
        chk("R4 B selected before collision", 1'b0);
        @(posedge clk);
        #0.5;
        chk("R5 collision switch to A", 1'b1);
        rst_a_n = 1'b0; #0.5;
        chk("R3 collision A asserts same cycle", 1'b0);
        rst_b_n = 1'b1; #0.5;
        chk("R4 collision B ignored", 1'b0);
    endtask

    task automatic t_reset_midway();
        @(negedge clk);
        rst_a_n = 1'b0; rst_b_n = 1'b1; rst = 1'b1; sel_req = 1'b1;
        after_edge();
        chk("R7 reset midway forces B", 1'b1);
        @(negedge clk);
        rst = 1'b0; #1;
        chk("R7 still B before capture", 1'b1);
        after_edge();
        chk("R1 A after release", 1'b0);
    endtask

    initial begin
        t_reset();
        t_select_a();
        t_pass_and_ignore();
        t_equal_switch();
        t_diff_switch();
        t_req_glitch();
        t_collide();
        t_reset_midway();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule